// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block joins two tri-stateable eight-bit buses, called A and B, and can pass data between them in either direction. Each direction has its own storage register with its own capture clock. The A-side register loads whatever is on port A. The B-side register loads whatever is on port B. A global active-low enable and a direction input decide which port, if either, the block drives.

For each direction, a select input chooses what the driven port carries. It can carry the live value of the opposite port, or the stored register value that belongs to the opposite port. The capture clocks ignore the enable and the direction input. A register can therefore be loaded while both ports are isolated, and it can also be loaded while it feeds a driven port. In the second case each capture edge steps new data across to the other bus.

Both ports are plain tri-state pins with an explicit output enable. The two enables are also brought out as outputs. This lets a surrounding bus model, or a bench, confirm that at most one side is ever driven.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: On a rising edge of `clk_a`, the A-side register takes the value present on `port_a`. On a rising edge of `clk_b`, the B-side register takes the value present on `port_b`. The two clocks are independent.
- R2: While `en_n` is 1, `a_drive_on` and `b_drive_on` are both 0 and the block drives neither port. A port that nothing else drives reads as all high impedance.
- R3: While `en_n` is 0, `toward_b` = 1 drives `port_b` only (`b_drive_on`=1, `a_drive_on`=0), and `toward_b` = 0 drives `port_a` only (`a_drive_on`=1, `b_drive_on`=0).
- R4: When `port_b` is driven, `a2b_use_store` = 0 puts the live value of `port_a` on it, and `a2b_use_store` = 1 puts the A-side register value on it.
- R5: When `port_a` is driven, `b2a_use_store` = 0 puts the live value of `port_b` on it, and `b2a_use_store` = 1 puts the B-side register value on it.
- R6: Captures happen under every setting of `en_n` and `toward_b`. This includes isolation, where either register or both registers may load on the same edge.
- R7: While `port_b` carries the A-side register value, a `clk_a` edge that captures new data makes `port_b` show that data before the next edge, with no further clock needed. The same holds for `port_a` with `clk_b`.
- R8: The two drive enables are never 1 together. When `toward_b` changes while `en_n` is 0, the two enables swap at the same instant.
- R9: An active-low `rst_n` clears both storage registers to zero asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both storage registers |
| clk_a | input | 1 | Capture clock of the A-side register |
| clk_b | input | 1 | Capture clock of the B-side register |
| en_n | input | 1 | Active-low global output enable |
| toward_b | input | 1 | Direction: 1 drives port B, 0 drives port A |
| a2b_use_store | input | 1 | Port B source: 0 live port A, 1 A-side register |
| b2a_use_store | input | 1 | Port A source: 0 live port B, 1 B-side register |
| port_a | inout | W | Bus A data |
| port_b | inout | W | Bus B data |
| a_drive_on | output | 1 | Block is driving port A |
| b_drive_on | output | 1 | Block is driving port B |

## Verification
The assertions sample at capture-clock edges. They assume that, at every such edge, each port is driven by exactly one party, so that no high-impedance or unknown value is ever captured. They also assume that reset is not pulsed between two edges of the same clock. The stimulus meets both assumptions. The bench always drives whichever port the block leaves undriven. It changes controls only while both capture clocks are low, and it releases both ports only during isolation checks in which no clock pulses. Reset is applied only at the start of the run.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Which side of the transceiver currently drives its bus.
  typedef enum logic [1:0] {
    SIDE_NONE = 2'b00,
    SIDE_A    = 2'b01,
    SIDE_B    = 2'b10
  } drive_side_e;

  // Source of the value placed on a driven port.
  typedef enum logic {
    SRC_LIVE  = 1'b0,
    SRC_STORE = 1'b1
  } path_src_e;

  function automatic drive_side_e pick_side(input logic en_n, input logic toward_b);
    if (en_n)          return SIDE_NONE;
    else if (toward_b) return SIDE_B;
    else               return SIDE_A;
  endfunction
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         cap_clk,
  input  logic [W-1:0] cap_d,
  output logic [W-1:0] store_q
);
  // Capture is never qualified by the enable or the direction.
  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= cap_d;
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import xcvr_pkg::*;
(
  input  logic en_n,
  input  logic toward_b,
  output logic drive_a,
  output logic drive_b
);
  drive_side_e side;

  // Both enables decode from one encoded side, so they cannot overlap.
  always_comb begin
    side    = pick_side(en_n, toward_b);
    drive_a = (side == SIDE_A);
    drive_b = (side == SIDE_B);
  end
endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         use_store,
  input  logic [W-1:0] live_d,
  input  logic [W-1:0] store_d,
  output logic [W-1:0] out_d
);
  path_src_e src;

  always_comb begin
    src   = path_src_e'(use_store);
    out_d = (src == SRC_STORE) ? store_d : live_d;
  end
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         en_n,
  input  logic         toward_b,
  input  logic         a2b_use_store,
  input  logic         b2a_use_store,
  inout  wire  [W-1:0] port_a,
  inout  wire  [W-1:0] port_b,
  output logic         a_drive_on,
  output logic         b_drive_on
);
  logic [W-1:0] a_store_q;
  logic [W-1:0] b_store_q;
  logic [W-1:0] to_b_d;
  logic [W-1:0] to_a_d;

  xcvr_store_reg #(.W(W)) u_store_a (
    .rst_n   (rst_n),
    .cap_clk (clk_a),
    .cap_d   (port_a),
    .store_q (a_store_q)
  );

  xcvr_store_reg #(.W(W)) u_store_b (
    .rst_n   (rst_n),
    .cap_clk (clk_b),
    .cap_d   (port_b),
    .store_q (b_store_q)
  );

  xcvr_drive_ctl u_ctl (
    .en_n     (en_n),
    .toward_b (toward_b),
    .drive_a  (a_drive_on),
    .drive_b  (b_drive_on)
  );

  xcvr_path_sel #(.W(W)) u_sel_ab (
    .use_store (a2b_use_store),
    .live_d    (port_a),
    .store_d   (a_store_q),
    .out_d     (to_b_d)
  );

  xcvr_path_sel #(.W(W)) u_sel_ba (
    .use_store (b2a_use_store),
    .live_d    (port_b),
    .store_d   (b_store_q),
    .out_d     (to_a_d)
  );

  assign port_a = a_drive_on ? to_a_d : {W{1'bz}};
  assign port_b = b_drive_on ? to_b_d : {W{1'bz}};
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         clk_a,
  input logic         clk_b,
  input logic         en_n,
  input logic         toward_b,
  input logic         a2b_use_store,
  input logic         b2a_use_store,
  input logic [W-1:0] port_a,
  input logic [W-1:0] port_b,
  input logic [W-1:0] a_store_q,
  input logic [W-1:0] b_store_q,
  input logic         a_drive_on,
  input logic         b_drive_on
);
  // Set once a capture edge has occurred out of reset, so $past is meaningful.
  logic a_seen, b_seen;
  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) a_seen <= 1'b0; else a_seen <= 1'b1;
  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) b_seen <= 1'b0; else b_seen <= 1'b1;

  p_capture_a_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_seen |-> a_store_q == $past(port_a));
  p_capture_b_r1: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_seen |-> b_store_q == $past(port_b));

  p_isolate_r2: assert property (@(posedge clk_a) disable iff (!rst_n)
    en_n |-> (!a_drive_on && !b_drive_on));

  p_dir_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
    !en_n |-> (b_drive_on == toward_b) && (a_drive_on == !toward_b));

  p_drive_b_val_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_drive_on |-> port_b == (a2b_use_store ? a_store_q : port_a));

  p_drive_a_val_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_drive_on |-> port_a == (b2a_use_store ? b_store_q : port_b));

  p_excl_a_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
    !(a_drive_on && b_drive_on));
  p_excl_b_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
    !(a_drive_on && b_drive_on));
endmodule

bind bidir_reg_xcvr xcvr_checker #(.W(W)) u_chk (
  .rst_n         (rst_n),
  .clk_a         (clk_a),
  .clk_b         (clk_b),
  .en_n          (en_n),
  .toward_b      (toward_b),
  .a2b_use_store (a2b_use_store),
  .b2a_use_store (b2a_use_store),
  .port_a        (port_a),
  .port_b        (port_b),
  .a_store_q     (a_store_q),
  .b_store_q     (b_store_q),
  .a_drive_on    (a_drive_on),
  .b_drive_on    (b_drive_on)
);

// File: tb/bidir_reg_xcvr_test.sv
module bidir_reg_xcvr_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, clk_a = 1'b0, clk_b = 1'b0;
  logic en_n = 1'b1, toward_b = 1'b0, ua = 1'b0, ub = 1'b0;
  logic tb_a_en = 1'b0, tb_b_en = 1'b0;
  logic [W-1:0] tb_a = '0, tb_b = '0;
  wire  [W-1:0] port_a, port_b;
  logic a_drive_on, b_drive_on;

  assign port_a = tb_a_en ? tb_a : {W{1'bz}};
  assign port_b = tb_b_en ? tb_b : {W{1'bz}};

  bidir_reg_xcvr #(.W(W)) uut (
    .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b), .en_n(en_n),
    .toward_b(toward_b), .a2b_use_store(ua), .b2a_use_store(ub),
    .port_a(port_a), .port_b(port_b),
    .a_drive_on(a_drive_on), .b_drive_on(b_drive_on));

  int checks = 0, errors = 0;
  logic [W-1:0] ra = '0, rb = '0;   // bench model of the two registers
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_pa();
    if (!en_n && !toward_b) return ub ? rb : tb_b;
    return tb_a;
  endfunction
  function automatic logic [W-1:0] exp_pb();
    if (!en_n && toward_b) return ua ? ra : tb_a;
    return tb_b;
  endfunction

  // Set controls and live data; the bench drives whatever the block leaves free.
  task automatic setup(input logic e, input logic d, input logic sa, input logic sb,
                       input logic [W-1:0] la, input logic [W-1:0] lb);
    @(negedge clk);
    en_n = e; toward_b = d; ua = sa; ub = sb; tb_a = la; tb_b = lb;
    tb_a_en = !(!e && !d);
    tb_b_en = !(!e && d);
    #1;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3 a_drive_on"}, W'(a_drive_on), W'(!en_n && !toward_b));
    chk({tag, " R3 b_drive_on"}, W'(b_drive_on), W'(!en_n && toward_b));
    chk({tag, " R8 exclusive"}, W'(a_drive_on & b_drive_on), '0);
    chk({tag, " R5 port_a"}, port_a, exp_pa());
    chk({tag, " R4 port_b"}, port_b, exp_pb());
  endtask

  // Pulse one or both capture clocks; the model takes the pre-edge port values.
  task automatic pulse(input bit pa, input bit pb);
    logic [W-1:0] na, nb;
    na = exp_pa(); nb = exp_pb();
    @(negedge clk);
    #1;
    if (pa) begin clk_a = 1'b1; ra = na; end
    if (pb) begin clk_b = 1'b1; rb = nb; end
    #2;
    clk_a = 1'b0; clk_b = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: registers clear on reset; check with the stored paths selected.
    setup(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h5A);
    pulse(1'b1, 1'b1);   // edges while in reset must not load
    ra = '0; rb = '0;
    rst_n = 1'b1;
    setup(1'b0, 1'b1, 1'b1, 1'b0, 8'h3C, 8'hC3);
    chk("R9 A reg after reset", port_b, 8'h00);
    setup(1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 8'hC3);
    chk("R9 B reg after reset", port_a, 8'h00);

    // R2: isolation, no drive, released ports float.
    setup(1'b1, 1'b1, 1'b1, 1'b1, 8'h11, 8'h22);
    tb_a_en = 1'b0; tb_b_en = 1'b0; #1;
    chk("R2 a_drive_on", W'(a_drive_on), '0);
    chk("R2 b_drive_on", W'(b_drive_on), '0);
    checks++;
    if (port_a !== {W{1'bz}} || port_b !== {W{1'bz}}) begin
      errors++;
      $display("FAIL R2 ports actual=%h/%h expected=zz/zz", port_a, port_b);
    end

    // R6: isolation loads one at a time, then both together.
    setup(1'b1, 1'b0, 1'b0, 1'b0, 8'h96, 8'h69);
    pulse(1'b1, 1'b0);
    setup(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
    chk("R6 A only loaded in isolation", port_b, 8'h96);
    setup(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
    chk("R6 B untouched in isolation", port_a, 8'h00);
    setup(1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, 8'hF0);
    pulse(1'b1, 1'b1);
    setup(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    chk("R6 A loaded with B", port_b, 8'h0F);
    setup(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    chk("R6 B loaded with A", port_a, 8'hF0);

    // Sweep all control settings with several data patterns (R1 R3 R4 R5 R6 R7).
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 3; p++) begin
        logic [W-1:0] la, lb;
        la = W'(c * 17 + p * 85 + 1);
        lb = ~la ^ W'(p * 51);
        setup(c[3], c[2], c[1], c[0], la, lb);
        check_all("sweep");
        pulse(p != 1, p != 2);           // R1 R6: ungated captures
        check_all("sweep post-edge R1");
        tb_a = la + 8'd7; tb_b = lb - 8'd3; #1;
        check_all("sweep new live R7");
        pulse(1'b1, 1'b1);               // R7: stored data steps across
        check_all("sweep step R7");
      end
    end

    // R8: direction flips while enabled swap the enables together.
    for (int k = 0; k < 4; k++) begin
      setup(1'b0, k[0], 1'b0, 1'b0, 8'h44, 8'h88);
      chk("R8 flip one-hot", W'(a_drive_on + b_drive_on), W'(1));
      chk("R8 flip side", W'(b_drive_on), W'(k[0]));
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule